// File: doc/BRIEF.md
# Two-Thread Shared Uop Issue Queue

This block is a small out-of-order issue queue that two hardware threads share. Each cycle it can take up to two uops on two insert lanes. Each uop carries its owning thread, a destination tag and two source tags, and each source tag has a ready flag. The queue stores only tags and ready flags, never operand values. A result-tag broadcast port wakes up waiting sources. Each cycle the queue issues at most one uop whose sources are both ready. When several uops qualify, it issues the one inserted earliest.

The issue choice never looks at which thread owns a uop. Fairness comes from admission instead. Each thread holds a reserved number of entries, and the other thread may never claim them. A thread may take a shared entry only while the free entries left over still cover the other thread's reservation. A per-thread full output tells the front end when that thread can no longer insert.

Top module: `sched_iq`

## Requirements
- R1: After reset the queue is empty. `disp_vld` is 0, both `full` bits are 0, and `in_ack` is 0 while no insert is offered.
- R2: Two uops can be accepted in one cycle, on lanes 0 and 1, from the same thread or from different threads. Lane 0 is evaluated first, and lane 1 is evaluated against the counts that include an accepted lane 0. `in_ack[k]` is 1 exactly when lane k's uop is stored.
- R3: Let occ_s be the number of entries held by the inserting thread and occ_o the number held by the other thread. An insert is accepted only if DEPTH - occ_s - occ_o > max(0, RSV - occ_o). A refused uop is dropped and never issues.
- R4: `full[t]` (bit 0 for thread 0, bit 1 for thread 1) is 1 exactly when the R3 rule, applied to the counts at the start of the cycle, refuses one more insert by thread t.
- R5: A stored source becomes ready when `wb_vld` is 1 and `wb_tag` equals its tag. In that same cycle the entry already counts as ready for issue.
- R6: An inserted source is ready if its input ready flag is 1, or if a broadcast of an equal tag arrives in the insert cycle. A new uop issues at the earliest in the cycle after its insert.
- R7: An entry is eligible for issue only when both of its sources are ready. The owning thread plays no part in the choice.
- R8: Among the eligible entries, the one inserted earliest is issued. Lane 0 counts as older than lane 1 in the same cycle.
- R9: `disp_vld`, `disp_tid` and `disp_dst` present the chosen uop combinationally in the current cycle. That entry is freed at the next clock edge, and at most one uop issues per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in0_vld | input | 1 | Lane 0 insert request |
| in0_tid | input | 1 | Lane 0 owning thread |
| in0_dst | input | TAG_W | Lane 0 destination tag |
| in0_src0 | input | TAG_W | Lane 0 first source tag |
| in0_rdy0 | input | 1 | Lane 0 first source already ready |
| in0_src1 | input | TAG_W | Lane 0 second source tag |
| in0_rdy1 | input | 1 | Lane 0 second source already ready |
| in1_vld | input | 1 | Lane 1 insert request |
| in1_tid | input | 1 | Lane 1 owning thread |
| in1_dst | input | TAG_W | Lane 1 destination tag |
| in1_src0 | input | TAG_W | Lane 1 first source tag |
| in1_rdy0 | input | 1 | Lane 1 first source already ready |
| in1_src1 | input | TAG_W | Lane 1 second source tag |
| in1_rdy1 | input | 1 | Lane 1 second source already ready |
| in_ack | output | 2 | Per-lane accept indication |
| wb_vld | input | 1 | Result-tag broadcast valid |
| wb_tag | input | TAG_W | Broadcast result tag |
| disp_vld | output | 1 | A uop issues this cycle |
| disp_tid | output | 1 | Thread of the issuing uop |
| disp_dst | output | TAG_W | Destination tag of the issuing uop |
| full | output | 2 | Per-thread insert refusal |

## Verification
The hardest state to reach from the ports is the reservation boundary. One thread must hold every entry except the other thread's reserve, and the other thread must then claim exactly those entries, two of them in a single cycle. Random traffic rarely gets there because broadcasts keep draining the queue. The bench therefore fills the queue with uops that wait on tags random traffic never broadcasts, probes both lanes at the limit, and then releases the waiting uops with directed broadcasts. Random phases follow, in which one thread dominates insertion and broadcasts are rare, so the reservation limit and the full outputs keep being hit under varied ages and wake orders.

// File: rtl/sched_iq_pkg.sv
package sched_iq_pkg;

  // Entries the other thread still needs to reach its reservation.
  function automatic int unsigned reserve_gap(int unsigned occ_other, int unsigned rsv);
    return (occ_other >= rsv) ? 0 : rsv - occ_other;
  endfunction

  // Admission rule: free entries must exceed the other thread's outstanding reserve.
  function automatic logic may_insert(int unsigned depth, int unsigned rsv,
                                      int unsigned occ_self, int unsigned occ_other);
    int unsigned used;
    used = occ_self + occ_other;
    if (used >= depth) return 1'b0;
    return (depth - used) > reserve_gap(occ_other, rsv);
  endfunction

endpackage

// File: rtl/sched_iq_entry.sv
module sched_iq_entry #(
  parameter int unsigned TAG_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             clear,
  input  logic             ld_tid,
  input  logic [TAG_W-1:0] ld_dst,
  input  logic [TAG_W-1:0] ld_src0,
  input  logic             ld_rdy0,
  input  logic [TAG_W-1:0] ld_src1,
  input  logic             ld_rdy1,
  input  logic             wb_vld,
  input  logic [TAG_W-1:0] wb_tag,
  output logic             busy,
  output logic             ready,
  output logic             own_tid,
  output logic [TAG_W-1:0] own_dst
);
  logic [TAG_W-1:0] src0, src1;
  logic             rdy0, rdy1;
  logic             wake0, wake1;

  // Wakeup covers both stored flags and a broadcast arriving this cycle.
  assign wake0 = rdy0 | (wb_vld && wb_tag == src0);
  assign wake1 = rdy1 | (wb_vld && wb_tag == src1);
  assign ready = busy & wake0 & wake1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      rdy0    <= 1'b0;
      rdy1    <= 1'b0;
      own_tid <= 1'b0;
      own_dst <= '0;
      src0    <= '0;
      src1    <= '0;
    end else if (load) begin
      busy    <= 1'b1;
      own_tid <= ld_tid;
      own_dst <= ld_dst;
      src0    <= ld_src0;
      src1    <= ld_src1;
      rdy0    <= ld_rdy0 | (wb_vld && wb_tag == ld_src0);
      rdy1    <= ld_rdy1 | (wb_vld && wb_tag == ld_src1);
    end else if (clear) begin
      busy    <= 1'b0;
    end else begin
      rdy0    <= wake0;
      rdy1    <= wake1;
    end
  end
endmodule

// File: rtl/sched_iq_age.sv
module sched_iq_age #(
  parameter int unsigned DEPTH = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DEPTH-1:0] busy,
  input  logic [DEPTH-1:0] ins_a,
  input  logic [DEPTH-1:0] ins_b,
  input  logic [DEPTH-1:0] ready,
  output logic [DEPTH-1:0] grant
);
  // elder[i][j] set: entry j was inserted before entry i.
  logic [DEPTH-1:0] elder [DEPTH];

  always_ff @(posedge clk) begin
    for (int k = 0; k < DEPTH; k++) begin
      if (!rst_n)        elder[k] <= '0;
      else if (ins_a[k]) elder[k] <= busy;
      else if (ins_b[k]) elder[k] <= busy | ins_a;
      else               elder[k] <= elder[k] & ~(ins_a | ins_b);
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_pick
    assign grant[i] = ready[i] & ~(|(elder[i] & ready));
  end
endmodule

// File: rtl/sched_iq_quota.sv
module sched_iq_quota
  import sched_iq_pkg::*;
#(
  parameter int unsigned DEPTH = 12,
  parameter int unsigned RSV   = 2,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    lane_vld,
  input  logic [1:0]    lane_tid,
  input  logic          rel_vld,
  input  logic          rel_tid,
  output logic [1:0]    lane_ack,
  output logic [1:0]    full,
  output logic [CW-1:0] occ0,
  output logic [CW-1:0] occ1
);
  int unsigned c0, c1, inc0, inc1, dec0, dec1;

  always_comb begin
    full[0] = !may_insert(DEPTH, RSV, 32'(occ0), 32'(occ1));
    full[1] = !may_insert(DEPTH, RSV, 32'(occ1), 32'(occ0));
    lane_ack[0] = lane_vld[0] && !full[lane_tid[0]];
    c0 = 32'(occ0);
    c1 = 32'(occ1);
    if (lane_ack[0]) begin
      if (lane_tid[0]) c1 = c1 + 1;
      else             c0 = c0 + 1;
    end
    lane_ack[1] = lane_vld[1] && (lane_tid[1] ? may_insert(DEPTH, RSV, c1, c0)
                                              : may_insert(DEPTH, RSV, c0, c1));
    inc0 = c0 - 32'(occ0) + ((lane_ack[1] && !lane_tid[1]) ? 1 : 0);
    inc1 = c1 - 32'(occ1) + ((lane_ack[1] &&  lane_tid[1]) ? 1 : 0);
    dec0 = (rel_vld && !rel_tid) ? 1 : 0;
    dec1 = (rel_vld &&  rel_tid) ? 1 : 0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ0 <= '0;
      occ1 <= '0;
    end else begin
      occ0 <= CW'(32'(occ0) + inc0 - dec0);
      occ1 <= CW'(32'(occ1) + inc1 - dec1);
    end
  end
endmodule

// File: rtl/sched_iq.sv
module sched_iq #(
  parameter int unsigned DEPTH = 12,
  parameter int unsigned TAG_W = 6,
  parameter int unsigned RSV   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in0_vld,
  input  logic             in0_tid,
  input  logic [TAG_W-1:0] in0_dst,
  input  logic [TAG_W-1:0] in0_src0,
  input  logic             in0_rdy0,
  input  logic [TAG_W-1:0] in0_src1,
  input  logic             in0_rdy1,
  input  logic             in1_vld,
  input  logic             in1_tid,
  input  logic [TAG_W-1:0] in1_dst,
  input  logic [TAG_W-1:0] in1_src0,
  input  logic             in1_rdy0,
  input  logic [TAG_W-1:0] in1_src1,
  input  logic             in1_rdy1,
  output logic [1:0]       in_ack,
  input  logic             wb_vld,
  input  logic [TAG_W-1:0] wb_tag,
  output logic             disp_vld,
  output logic             disp_tid,
  output logic [TAG_W-1:0] disp_dst,
  output logic [1:0]       full
);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  // Named internal events, observed by the bound checker.
  logic [DEPTH-1:0] entry_busy, entry_ready, disp_grant;
  logic [DEPTH-1:0] slot_a, slot_b, load_a, load_b;
  logic [DEPTH-1:0] ent_tid;
  logic [TAG_W-1:0] ent_dst [DEPTH];
  logic [CW-1:0]    occ_t0, occ_t1;

  sched_iq_quota #(.DEPTH(DEPTH), .RSV(RSV)) u_quota (
    .clk      (clk),
    .rst_n    (rst_n),
    .lane_vld ({in1_vld, in0_vld}),
    .lane_tid ({in1_tid, in0_tid}),
    .rel_vld  (disp_vld),
    .rel_tid  (disp_tid),
    .lane_ack (in_ack),
    .full     (full),
    .occ0     (occ_t0),
    .occ1     (occ_t1)
  );

  // First and second free slot; lane 1 takes the first when lane 0 is idle.
  always_comb begin
    int nfree;
    nfree  = 0;
    slot_a = '0;
    slot_b = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!entry_busy[i]) begin
        if (nfree == 0)      slot_a[i] = 1'b1;
        else if (nfree == 1) slot_b[i] = 1'b1;
        nfree = nfree + 1;
      end
    end
    load_a = in_ack[0] ? slot_a : '0;
    load_b = in_ack[1] ? (in_ack[0] ? slot_b : slot_a) : '0;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    sched_iq_entry #(.TAG_W(TAG_W)) u_ent (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load_a[i] | load_b[i]),
      .clear   (disp_grant[i]),
      .ld_tid  (load_a[i] ? in0_tid  : in1_tid),
      .ld_dst  (load_a[i] ? in0_dst  : in1_dst),
      .ld_src0 (load_a[i] ? in0_src0 : in1_src0),
      .ld_rdy0 (load_a[i] ? in0_rdy0 : in1_rdy0),
      .ld_src1 (load_a[i] ? in0_src1 : in1_src1),
      .ld_rdy1 (load_a[i] ? in0_rdy1 : in1_rdy1),
      .wb_vld  (wb_vld),
      .wb_tag  (wb_tag),
      .busy    (entry_busy[i]),
      .ready   (entry_ready[i]),
      .own_tid (ent_tid[i]),
      .own_dst (ent_dst[i])
    );
  end

  sched_iq_age #(.DEPTH(DEPTH)) u_age (
    .clk   (clk),
    .rst_n (rst_n),
    .busy  (entry_busy),
    .ins_a (load_a),
    .ins_b (load_b),
    .ready (entry_ready),
    .grant (disp_grant)
  );

  always_comb begin
    disp_vld = |disp_grant;
    disp_tid = 1'b0;
    disp_dst = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (disp_grant[i]) begin
        disp_tid = disp_tid | ent_tid[i];
        disp_dst = disp_dst | ent_dst[i];
      end
    end
  end
endmodule

// File: rtl/sched_iq_chk.sv
module sched_iq_chk #(
  parameter int unsigned DEPTH = 12,
  parameter int unsigned RSV   = 2,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [DEPTH-1:0] busy,
  input logic [DEPTH-1:0] grant,
  input logic             in0_vld,
  input logic             in0_tid,
  input logic [1:0]       in_ack,
  input logic [1:0]       full,
  input logic [CW-1:0]    occ0,
  input logic [CW-1:0]    occ1,
  input logic             disp_vld
);
  int unsigned hold0, hold1;
  always_comb begin
    hold0 = (32'(occ0) > RSV) ? 32'(occ0) : RSV;
    hold1 = (32'(occ1) > RSV) ? 32'(occ1) : RSV;
  end

  a_r9_single_issue: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  a_r9_entry_freed: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0) |=> ((busy & $past(grant)) == '0));

  a_r3_reserve_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(occ0) + hold1 <= DEPTH) && (32'(occ1) + hold0 <= DEPTH));

  a_r4_full_refuses: assert property (@(posedge clk) disable iff (!rst_n)
    (in0_vld && full[in0_tid]) |-> !in_ack[0]);

  a_r2_count_matches: assert property (@(posedge clk) disable iff (!rst_n)
    32'(occ0) + 32'(occ1) == 32'($countones(busy)));

  a_r1_empty_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (busy == '0) |-> !disp_vld);
endmodule

bind sched_iq sched_iq_chk #(.DEPTH(DEPTH), .RSV(RSV)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (entry_busy),
  .grant    (disp_grant),
  .in0_vld  (in0_vld),
  .in0_tid  (in0_tid),
  .in_ack   (in_ack),
  .full     (full),
  .occ0     (occ_t0),
  .occ1     (occ_t1),
  .disp_vld (disp_vld)
);

// File: tb/sched_iq_tb.sv
`timescale 1ns/1ps
module sched_iq_tb;
  localparam int DEPTH = 12;
  localparam int TAG_W = 6;
  localparam int RSV   = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic in0_vld, in0_tid, in0_rdy0, in0_rdy1;
  logic in1_vld, in1_tid, in1_rdy0, in1_rdy1;
  logic [TAG_W-1:0] in0_dst, in0_src0, in0_src1, in1_dst, in1_src0, in1_src1;
  logic wb_vld;
  logic [TAG_W-1:0] wb_tag;
  logic [1:0] in_ack, full;
  logic disp_vld, disp_tid;
  logic [TAG_W-1:0] disp_dst;

  always #10 clk = ~clk;

  sched_iq #(.DEPTH(DEPTH), .TAG_W(TAG_W), .RSV(RSV)) u_dut (.*);

  int n_chk = 0, n_fail = 0;

  // Bench model: entries kept with a sequence number for age.
  bit m_v [DEPTH];
  bit m_tid [DEPTH];
  int m_dst [DEPTH], m_s0 [DEPTH], m_s1 [DEPTH], m_seq [DEPTH];
  bit m_r0 [DEPTH], m_r1 [DEPTH];
  int seq_ctr = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R3 restated: leftover room after the insert must still cover the other thread's reserve.
  function automatic bit allowed(int mine, int theirs);
    int left, owed;
    left = DEPTH - mine - theirs - 1;
    owed = (theirs < RSV) ? RSV - theirs : 0;
    return left >= owed;
  endfunction

  function automatic bit hit(int tag);
    return wb_vld && (int'(wb_tag) == tag);
  endfunction

  task automatic model_put(bit tid, int dst, int s0, bit r0, int s1, bit r1);
    for (int i = 0; i < DEPTH; i++) begin
      if (!m_v[i]) begin
        m_v[i] = 1; m_tid[i] = tid; m_dst[i] = dst;
        m_s0[i] = s0; m_s1[i] = s1;
        m_r0[i] = r0 | hit(s0); m_r1[i] = r1 | hit(s1);
        m_seq[i] = seq_ctr++;
        return;
      end
    end
  endtask

  // Compare this cycle's outputs with the model, then advance the model past the edge.
  task automatic step();
    int cnt [2];
    bit ea0, ea1, ev;
    int best;
    #1;
    cnt[0] = 0; cnt[1] = 0;
    for (int i = 0; i < DEPTH; i++) if (m_v[i]) cnt[m_tid[i]]++;
    chk("R4 full[0]", int'(full[0]), int'(!allowed(cnt[0], cnt[1])));
    chk("R4 full[1]", int'(full[1]), int'(!allowed(cnt[1], cnt[0])));
    ea0 = in0_vld && allowed(cnt[in0_tid], cnt[!in0_tid]);
    if (ea0) cnt[in0_tid]++;
    ea1 = in1_vld && allowed(cnt[in1_tid], cnt[!in1_tid]);
    chk("R2/R3 lane0 accept", int'(in_ack[0]), int'(ea0));
    chk("R2/R3 lane1 accept", int'(in_ack[1]), int'(ea1));
    best = -1;
    for (int i = 0; i < DEPTH; i++)
      if (m_v[i] && (m_r0[i] || hit(m_s0[i])) && (m_r1[i] || hit(m_s1[i])))
        if (best < 0 || m_seq[i] < m_seq[best]) best = i;
    ev = (best >= 0);
    chk("R5/R6/R7 disp_vld", int'(disp_vld), int'(ev));
    if (ev) begin
      chk("R8/R9 disp_tid", int'(disp_tid), int'(m_tid[best]));
      chk("R8/R9 disp_dst", int'(disp_dst), m_dst[best]);
      m_v[best] = 0;
    end
    for (int i = 0; i < DEPTH; i++) begin
      if (hit(m_s0[i])) m_r0[i] = 1;
      if (hit(m_s1[i])) m_r1[i] = 1;
    end
    if (ea0) model_put(in0_tid, int'(in0_dst), int'(in0_src0), in0_rdy0, int'(in0_src1), in0_rdy1);
    if (ea1) model_put(in1_tid, int'(in1_dst), int'(in1_src0), in1_rdy0, int'(in1_src1), in1_rdy1);
    @(negedge clk);
  endtask

  task automatic idle();
    in0_vld = 0; in1_vld = 0; wb_vld = 0;
    in0_tid = 0; in1_tid = 0; in0_rdy0 = 0; in0_rdy1 = 0; in1_rdy0 = 0; in1_rdy1 = 0;
    in0_dst = '0; in0_src0 = '0; in0_src1 = '0; in1_dst = '0; in1_src0 = '0; in1_src1 = '0;
    wb_tag = '0;
  endtask

  task automatic lane0(bit tid, int dst, int s0, bit r0, int s1, bit r1);
    in0_vld = 1; in0_tid = tid; in0_dst = TAG_W'(dst);
    in0_src0 = TAG_W'(s0); in0_rdy0 = r0; in0_src1 = TAG_W'(s1); in0_rdy1 = r1;
  endtask

  task automatic lane1(bit tid, int dst, int s0, bit r0, int s1, bit r1);
    in1_vld = 1; in1_tid = tid; in1_dst = TAG_W'(dst);
    in1_src0 = TAG_W'(s0); in1_rdy0 = r0; in1_src1 = TAG_W'(s1); in1_rdy1 = r1;
  endtask

  task automatic rnd(int phase);
    idle();
    // Phase 0: thread 0 floods, broadcasts rare. Phase 1: mixed and busy.
    if ($urandom % 4 != 0)
      lane0((phase == 0) ? ($urandom % 6 == 0) : 1'($urandom), $urandom % 64,
            $urandom % 16, ($urandom % 3 == 0), $urandom % 16, ($urandom % 3 == 0));
    if ($urandom % 2 == 0)
      lane1(1'($urandom), $urandom % 64,
            $urandom % 16, ($urandom % 3 == 0), $urandom % 16, ($urandom % 3 == 0));
    wb_vld = (phase == 0) ? ($urandom % 5 == 0) : ($urandom % 3 != 0);
    wb_tag = TAG_W'($urandom % 16);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < DEPTH; i++) m_v[i] = 0;
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1: empty after reset
    chk("R1 disp_vld", int'(disp_vld), 0);
    chk("R1 full", int'(full), 0);
    chk("R1 in_ack", int'(in_ack), 0);
    @(negedge clk);

    // R3/R4: thread 0 fills to the reserve limit with uops waiting on tags 40/41
    for (int k = 0; k < 12; k++) begin
      idle(); lane0(0, k, 40, 0, 41, 0); step();
    end
    idle(); #1;
    chk("R4 thread 0 full at limit", int'(full), 1);
    // R2/R3: thread 1 claims both reserved entries in one cycle
    idle(); lane0(1, 50, 40, 0, 41, 0); lane1(1, 51, 40, 0, 41, 0); #1;
    chk("R2 both lanes accepted", int'(in_ack), 3);
    step();
    idle(); #1;
    chk("R4 both threads full", int'(full), 3);
    idle(); lane0(0, 60, 40, 0, 41, 0); lane1(1, 61, 40, 0, 41, 0); #1;
    chk("R3 inserts dropped when full", int'(in_ack), 0);
    step();
    // drain through directed broadcasts
    idle(); wb_vld = 1; wb_tag = 40; step();
    idle(); wb_vld = 1; wb_tag = 41; step();
    for (int k = 0; k < 12; k++) begin idle(); step(); end
    idle(); #1;
    chk("R9 drained", int'(disp_vld), 0);
    chk("R4 full clears", int'(full), 0);

    // R5/R8: same-cycle wake of two entries, older one issues first
    idle(); lane0(0, 20, 54, 0, 54, 0); lane1(1, 21, 54, 0, 54, 1); step();
    idle(); wb_vld = 1; wb_tag = 54; #1;
    chk("R5 wake issues in broadcast cycle", int'(disp_vld), 1);
    chk("R8 oldest issues", int'(disp_dst), 20);
    step();
    idle(); #1;
    chk("R8 younger follows", int'(disp_dst), 21);
    step();

    // R7: thread 1 entry is older; issue ignores thread number
    idle(); lane0(1, 30, 55, 0, 55, 1); lane1(0, 31, 55, 0, 55, 1); step();
    idle(); wb_vld = 1; wb_tag = 55; #1;
    chk("R7 thread 1 issues first", int'(disp_tid), 1);
    chk("R7 dst", int'(disp_dst), 30);
    step();
    idle(); step();

    // R6: broadcast in insert cycle is captured; issue next cycle
    idle(); lane0(0, 33, 56, 0, 57, 1); wb_vld = 1; wb_tag = 56; #1;
    chk("R6 no issue in insert cycle", int'(disp_vld), 0);
    step();
    idle(); #1;
    chk("R6 issues next cycle", int'(disp_dst), 33);
    step();

    // Random phases checked cycle by cycle against the model
    for (int k = 0; k < 1500; k++) begin rnd(0); step(); end
    for (int k = 0; k < 1500; k++) begin rnd(1); step(); end
    for (int k = 0; k < 64; k++) begin idle(); wb_vld = 1; wb_tag = TAG_W'(k % 16); step(); end
    idle(); #1;
    chk("R9 queue empty at end", int'(disp_vld), 0);
    chk("R4 full low at end", int'(full), 0);
    finish_run();
  end
endmodule